// File: doc/BRIEF.md
# UART Receive Status and Line-Break Detector

This block keeps the read-only status flags of a UART: receive overrun, parity and framing errors, an error summary, line break, the received ninth data bit and transmitter activity. It sits beside the receiver and transmitter datapaths. It reacts to single-cycle event strobes from those datapaths and to a status-read strobe from the register interface, and it presents both the individual flags and one packed status byte.

Break detection watches the serial receive line through a two-stage synchronizer. After the receiver reports a missing stop bit, the block counts bit-time ticks while the line stays low. When the count reaches the threshold, ten bit times by default, the break flag sets. A status read clears the break flag only if the line has already recovered. If the break is still being driven at the read, the flag clears by itself once the line goes high again.

Top module: `uart_rx_status_flags`

## Requirements
- R1: A character load (`char_load_evt`) while the receive buffer still holds an unread character, with no buffer read (`buf_read_evt`) in the same cycle, sets `overrun_flag` on the next clock. The buffer counts as holding a character from a load until the next buffer read.
- R2: A status read (`status_rd`) clears the parity, framing and overrun flags on the next clock. A set event for a flag in the same cycle as the read wins, and that flag stays 1.
- R3: `error_flag` is 1 exactly when at least one of the parity, framing or overrun flags is 1. It returns to 0 as soon as all three are 0.
- R4: `break_flag` sets on the bit tick that brings the count of ticks to BREAK_BITS (10 by default). Only ticks that arrive after a framing-error strobe, with the synchronized line low throughout, are counted. The count restarts when the line goes high and does not advance past BREAK_BITS.
- R5: A low line never sets `break_flag` if no framing-error strobe came first, however many ticks pass.
- R6: A status read while the synchronized line is low leaves `break_flag` at 1. The flag then clears one clock after the synchronized line goes high. A status read while the synchronized line is high clears it on the next clock.
- R7: `rx_line` passes through a two-flop synchronizer that resets to 1. A change on the pin reaches the break logic after two clocks.
- R8: On a character load, `ninth_flag` takes `ninth_bit_in` when `mode_9bit` is 1 and takes 0 otherwise. It holds between loads.
- R9: `tx_start_evt` sets `tx_busy_flag` and `tx_done_evt` (end of the last frame bit) clears it. If both arrive in the same cycle, the start wins.
- R10: `status_word` packs the flags as follows: bit 0 parity, bit 1 framing, bit 2 overrun, bit 3 error summary, bit 4 break, bit 5 ninth bit, bit 6 transmit busy, bit 7 zero. After reset it reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_line | input | 1 | Serial receive pin (asynchronous) |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| parity_err_evt | input | 1 | Receiver parity error strobe |
| frame_err_evt | input | 1 | Receiver missing-stop-bit strobe |
| char_load_evt | input | 1 | Character moved into the receive buffer |
| buf_read_evt | input | 1 | Receive buffer read by software |
| ninth_bit_in | input | 1 | Ninth data bit of the loaded character |
| mode_9bit | input | 1 | 9-bit data format selected |
| tx_start_evt | input | 1 | Transmitter started a frame |
| tx_done_evt | input | 1 | Transmitter finished the last frame bit |
| status_rd | input | 1 | Status register read strobe |
| overrun_flag | output | 1 | Receive overrun |
| error_flag | output | 1 | Any receive error present |
| break_flag | output | 1 | Line break detected |
| ninth_flag | output | 1 | Received ninth data bit |
| tx_busy_flag | output | 1 | Transmitter active |
| status_word | output | 8 | Packed status byte |

## Verification
The in-line assertions check rules that hold on every cycle: a load into an occupied buffer raises overrun, an error strobe always lands its flag even when a read clears in the same cycle, a read with no new events empties the error summary, a held-low line keeps the break flag, the break flag only rises at the full tick count on a low line, and a lone completion strobe drops transmit-busy. Other behaviour needs the bench's scenarios. Only they show the exact tick count at which the break sets, that a low line with no prior framing error never raises break, that the flag waits for the line to recover after a read, the synchronizer latency, and the ninth-bit mode selection. The bench's behavioural model covers all of these and is compared with the outputs on every clock.

// File: rtl/uart_rx_status_flags.sv
module uart_rx_status_flags #(
  parameter int BREAK_BITS = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_line,
  input  logic       bit_tick,
  input  logic       parity_err_evt,
  input  logic       frame_err_evt,
  input  logic       char_load_evt,
  input  logic       buf_read_evt,
  input  logic       ninth_bit_in,
  input  logic       mode_9bit,
  input  logic       tx_start_evt,
  input  logic       tx_done_evt,
  input  logic       status_rd,
  output logic       overrun_flag,
  output logic       error_flag,
  output logic       break_flag,
  output logic       ninth_flag,
  output logic       tx_busy_flag,
  output logic [7:0] status_word
);
  localparam int CW = $clog2(BREAK_BITS + 1);
  localparam logic [CW-1:0] BRK_FULL = CW'(BREAK_BITS);
  localparam logic [CW-1:0] BRK_LAST = CW'(BREAK_BITS - 1);

  logic [1:0]    sync_q;
  logic          rx_s;
  logic          buf_full, parity_flag, frame_flag;
  logic          armed, rd_pend;
  logic [CW-1:0] brk_cnt;
  logic          ovr_hit, brk_hit;

  assign rx_s    = sync_q[1];
  assign ovr_hit = char_load_evt & buf_full & ~buf_read_evt;
  assign brk_hit = armed & ~rx_s & bit_tick & (brk_cnt == BRK_LAST);

  // receive-line synchronizer (R7)
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], rx_line};

  // buffer occupancy and error flags
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      buf_full     <= 1'b0;
      parity_flag  <= 1'b0;
      frame_flag   <= 1'b0;
      overrun_flag <= 1'b0;
    end else begin
      buf_full     <= char_load_evt | (buf_full & ~buf_read_evt);
      parity_flag  <= parity_err_evt | (parity_flag  & ~status_rd);
      frame_flag   <= frame_err_evt  | (frame_flag   & ~status_rd);
      overrun_flag <= ovr_hit        | (overrun_flag & ~status_rd);
    end

  assign error_flag = parity_flag | frame_flag | overrun_flag;

  // break detection
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      armed      <= 1'b0;
      brk_cnt    <= '0;
      rd_pend    <= 1'b0;
      break_flag <= 1'b0;
    end else begin
      if (rx_s)               armed <= 1'b0;
      else if (frame_err_evt) armed <= 1'b1;

      if (rx_s) brk_cnt <= '0;
      else if (armed && bit_tick && brk_cnt != BRK_FULL) brk_cnt <= brk_cnt + 1'b1;

      if (rx_s)                         rd_pend <= 1'b0;
      else if (status_rd && break_flag) rd_pend <= 1'b1;

      if (brk_hit)                           break_flag <= 1'b1;
      else if (rx_s && (status_rd || rd_pend)) break_flag <= 1'b0;
    end

  // ninth bit and transmitter activity
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ninth_flag   <= 1'b0;
      tx_busy_flag <= 1'b0;
    end else begin
      if (char_load_evt) ninth_flag <= mode_9bit & ninth_bit_in;
      if (tx_start_evt)     tx_busy_flag <= 1'b1;
      else if (tx_done_evt) tx_busy_flag <= 1'b0;
    end

  assign status_word = {1'b0, tx_busy_flag, ninth_flag, break_flag,
                        error_flag, overrun_flag, frame_flag, parity_flag};

  assert_overrun_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (char_load_evt && buf_full && !buf_read_evt) |=> overrun_flag);

  assert_set_beats_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (parity_err_evt || frame_err_evt) |=> error_flag);

  assert_summary_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && !parity_err_evt && !frame_err_evt && !char_load_evt) |=> !error_flag);

  assert_break_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(break_flag) |-> (brk_cnt == BRK_FULL && !rx_s));

  assert_break_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (break_flag && !rx_s) |=> break_flag);

  assert_tx_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done_evt && !tx_start_evt) |=> !tx_busy_flag);
endmodule

// File: tb/uart_rx_status_flags_bench.sv
module uart_rx_status_flags_bench;
  localparam int B = 10;
  logic clk = 0, rst_n = 0;
  logic rx_line = 1, bit_tick = 0, parity_err_evt = 0, frame_err_evt = 0;
  logic char_load_evt = 0, buf_read_evt = 0, ninth_bit_in = 0, mode_9bit = 0;
  logic tx_start_evt = 0, tx_done_evt = 0, status_rd = 0;
  logic overrun_flag, error_flag, break_flag, ninth_flag, tx_busy_flag;
  logic [7:0] status_word;

  always #2.5 clk = ~clk;

  uart_rx_status_flags #(.BREAK_BITS(B)) u_uart_rx_status_flags (.*);

  int tests = 0, fails = 0;
  bit done = 0;

  // behavioural reference model
  bit m_s1 = 1, m_s2 = 1, m_full, m_par, m_frm, m_ovr, m_arm, m_pend, m_brk, m_nin, m_tx;
  int m_cnt;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 = 1; m_s2 = 1; m_full = 0; m_par = 0; m_frm = 0; m_ovr = 0;
      m_arm = 0; m_pend = 0; m_brk = 0; m_nin = 0; m_tx = 0; m_cnt = 0;
    end else begin
      bit rxs, ov, a0, p0, b0;
      int c0;
      rxs = m_s2; a0 = m_arm; p0 = m_pend; b0 = m_brk; c0 = m_cnt;
      ov = char_load_evt && m_full && !buf_read_evt;
      m_full = char_load_evt || (m_full && !buf_read_evt);
      m_par = parity_err_evt || (m_par && !status_rd);
      m_frm = frame_err_evt || (m_frm && !status_rd);
      m_ovr = ov || (m_ovr && !status_rd);
      if (a0 && !rxs && bit_tick && c0 == B - 1) m_brk = 1;
      else if (rxs && (status_rd || p0)) m_brk = 0;
      m_pend = rxs ? 0 : ((status_rd && b0) ? 1 : p0);
      m_cnt = rxs ? 0 : ((a0 && bit_tick && c0 < B) ? c0 + 1 : c0);
      m_arm = rxs ? 0 : (frame_err_evt ? 1 : a0);
      if (char_load_evt) m_nin = mode_9bit && ninth_bit_in;
      if (tx_start_evt) m_tx = 1; else if (tx_done_evt) m_tx = 0;
      m_s2 = m_s1; m_s1 = rx_line;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) if (rst_n && !done) begin
    chk("R1", overrun_flag, m_ovr);
    chk("R3", error_flag, m_par | m_frm | m_ovr);
    chk("R4", break_flag, m_brk);
    chk("R8", ninth_flag, m_nin);
    chk("R9", tx_busy_flag, m_tx);
    chk("R10", status_word, {1'b0, m_tx, m_nin, m_brk, m_par | m_frm | m_ovr, m_ovr, m_frm, m_par});
  end

  task automatic cyc(input int n = 1);
    repeat (n) @(negedge clk);
  endtask
  task automatic tick(input int n);
    repeat (n) begin bit_tick = 1; cyc(); bit_tick = 0; cyc(); end
  endtask

  initial begin
    cyc(3);
    chk("R10 reset", status_word, 8'h00);
    rst_n = 1; cyc();
    chk("R10 after reset", status_word, 8'h00);

    // R2 / R3: parity set, read clears
    parity_err_evt = 1; cyc(); parity_err_evt = 0;
    chk("R2 parity set", status_word[0], 1); chk("R3 summary", error_flag, 1);
    status_rd = 1; cyc(); status_rd = 0;
    chk("R2 read clears", status_word[0], 0); chk("R3 summary clears", error_flag, 0);
    // R2: set beats read in same cycle
    frame_err_evt = 1; status_rd = 1; cyc(); frame_err_evt = 0; status_rd = 0;
    chk("R2 set priority", status_word[1], 1);
    status_rd = 1; cyc(); status_rd = 0;
    chk("R2 framing cleared", status_word[1], 0);
    cyc(3); // framing strobe with high line must not arm break (R5)

    // R1: load, load without read -> overrun
    char_load_evt = 1; cyc(); char_load_evt = 0;
    chk("R1 single load", overrun_flag, 0);
    char_load_evt = 1; buf_read_evt = 1; cyc(); char_load_evt = 0; buf_read_evt = 0;
    chk("R1 load with read", overrun_flag, 0);
    char_load_evt = 1; cyc(); char_load_evt = 0;
    chk("R1 overrun", overrun_flag, 1); chk("R3 overrun summary", error_flag, 1);
    status_rd = 1; cyc(); status_rd = 0;
    chk("R2 overrun cleared", overrun_flag, 0);
    buf_read_evt = 1; cyc(); buf_read_evt = 0;

    // R8: ninth bit
    mode_9bit = 1; ninth_bit_in = 1; char_load_evt = 1; cyc(); char_load_evt = 0;
    chk("R8 ninth captured", ninth_flag, 1);
    ninth_bit_in = 0; cyc(2);
    chk("R8 ninth held", ninth_flag, 1);
    mode_9bit = 0; ninth_bit_in = 1; buf_read_evt = 1; char_load_evt = 1; cyc();
    char_load_evt = 0; buf_read_evt = 0;
    chk("R8 8-bit mode", ninth_flag, 0);
    buf_read_evt = 1; cyc(); buf_read_evt = 0;

    // R9: transmitter
    tx_start_evt = 1; cyc(); tx_start_evt = 0;
    chk("R9 busy", tx_busy_flag, 1);
    tx_start_evt = 1; tx_done_evt = 1; cyc(); tx_start_evt = 0; tx_done_evt = 0;
    chk("R9 start wins", tx_busy_flag, 1);
    tx_done_evt = 1; cyc(); tx_done_evt = 0;
    chk("R9 done", tx_busy_flag, 0);

    // R5: low line without framing error
    rx_line = 0; cyc(3); tick(B + 3);
    chk("R5 no break", break_flag, 0);
    rx_line = 1; cyc(3);

    // R4 / R7 / R6: break after framing error
    rx_line = 0; cyc();
    frame_err_evt = 1; cyc(); frame_err_evt = 0; // line not yet synchronized: R7
    cyc(2); tick(B);
    chk("R7 sync latency disarms", break_flag, 0);
    rx_line = 1; cyc(3); rx_line = 0; cyc(3);
    frame_err_evt = 1; cyc(); frame_err_evt = 0;
    tick(B - 1);
    chk("R4 one short", break_flag, 0);
    tick(1);
    chk("R4 break set", break_flag, 1);
    tick(3);
    chk("R4 saturated", break_flag, 1);
    status_rd = 1; cyc(); status_rd = 0; cyc(2);
    chk("R6 read while low keeps", break_flag, 1);
    rx_line = 1; cyc(2);
    chk("R7 still synchronizing", break_flag, 1);
    cyc();
    chk("R6 auto clear on recovery", break_flag, 0);

    // R6: break, line recovers, then read clears
    rx_line = 0; cyc(3); frame_err_evt = 1; cyc(); frame_err_evt = 0;
    status_rd = 1; cyc(); status_rd = 0;
    tick(B);
    chk("R6 break again", break_flag, 1);
    rx_line = 1; cyc(5);
    chk("R6 no pending read keeps", break_flag, 1);
    status_rd = 1; cyc(); status_rd = 0;
    chk("R6 read after recovery", break_flag, 0);
    status_rd = 1; cyc(); status_rd = 0;
    chk("R10 final", status_word, 8'h00);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1; tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule